// File: doc/BRIEF.md
# Serial EEPROM Bus Protocol Engine

This block is the command and data engine of a two-wire addressed 256-byte serial memory. A bus front end, outside this block, turns the pins into single-cycle events: a start condition, a stop condition, an SCL falling edge, and a sampled data bit on each SCL rising edge. The engine matches the 7-bit device select, keeps an 8-bit word pointer, and decodes the transfer types: byte write, page write, current-address read, random read and sequential read. It produces the open-drain pull-down request for SDA, which is used for acknowledges and for read data.

Write data is collected in a 16-entry page buffer. A stop at a byte boundary hands the buffer to memory and pulses a launch strobe toward the external write-cycle controller. While that controller reports busy, the engine ignores every bus event and leaves SDA released. This silence is what lets a master poll for completion. A write-lock input turns the array read-only. Device addresses and word addresses are still acknowledged, but data bytes are refused. Read data is fetched from a synchronous 256x8 memory with one cycle of read latency.

Top module: `eel_link_engine`

## Requirements
- R1: A control byte is received MSB first, and the engine compares bits 7:4 with 1010 and bits 3:1 with `dev_sel`. If both match, it pulls SDA low for the 9th (acknowledge) slot. Bit 0 of the control byte selects read when it is 1 and write when it is 0.
- R2: After a control byte that does not match, SDA stays released. All later bits are ignored until the next start.
- R3: In a write transfer, the first byte after the control byte loads the word pointer. Each following byte is data, and each byte is acknowledged.
- R4: A stop that arrives on a byte boundary after at least one accepted data byte does three things. It pulses `wr_launch` for exactly one cycle, writes every received byte to its address, and releases SDA.
- R5: During a write, the pointer advances only within its 16-byte page, so its low 4 bits wrap. If more than 16 bytes are sent, the earlier bytes of the page are overwritten.
- R6: While `wr_lock` is 1, the control byte and the word address are still acknowledged. The first data byte is not acknowledged, the stop does not launch a write, and memory is left unchanged.
- R7: While `cycle_busy` is 1, the engine ignores start, stop and bit events and keeps SDA released, so a control byte gets no acknowledge. Once the flag clears, a new start is acknowledged again.
- R8: Read data is driven MSB first. Bit 7 appears on the first SCL fall after the acknowledge, and SDA is released for the master's acknowledge slot.
- R9: The pointer always holds the last accessed address plus one. A current-address read therefore returns address n+1 after an access to address n.
- R10: A random read sends a control byte for write, then the word address, then a repeated start and a control byte for read. The engine then returns data starting at the loaded address.
- R11: When the master acknowledges during a read, the next byte follows, and the pointer wraps from 255 to 0. When the master does not acknowledge, the engine stops driving until the next start.
- R12: A start or a stop in the middle of a byte aborts the transfer. Any pending write data is discarded without a launch, SDA is released, and a start restarts control-byte reception.
- R13: After reset, SDA is released, no memory read or write is issued, and `wr_launch` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start or repeated start detected (one-cycle pulse) |
| bus_stop | input | 1 | Stop detected (one-cycle pulse) |
| scl_fall | input | 1 | SCL falling edge (one-cycle pulse); the engine updates its SDA drive here |
| bit_valid | input | 1 | SCL rising edge with a sampled SDA bit (one-cycle pulse) |
| bit_val | input | 1 | Sampled SDA level for `bit_valid` |
| dev_sel | input | 3 | Strapped device select compared with control bits 3:1 |
| wr_lock | input | 1 | Write lock; 1 makes the array read-only |
| cycle_busy | input | 1 | External write cycle in progress |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 8 | Memory address for read or write |
| mem_wdata | output | 8 | Memory write data |
| wr_launch | output | 1 | One-cycle request to start the external write cycle |

## Verification
On every cycle, the assertions check the silence rules. SDA is released after any start or stop and throughout a busy period. No read is issued while busy. A locked array never launches a write, the launch is a single pulse, and the memory port never reads and writes at once.

Three behaviours depend on data carried across whole transfers, so only the bench scenarios can show them. These are the byte-by-byte acknowledge pattern and the read data bits, the page wrap and overwrite order, and the pointer value seen by a later current-address read. The bench compares SDA against its own expectation on every clock, and it checks each transfer against a reference array.

// File: rtl/eel_pkg.sv
package eel_pkg;

    localparam int          BYTE_W      = 8;
    localparam logic [3:0]  FAMILY_CODE = 4'b1010;
    localparam logic [3:0]  ACK_SLOT    = 4'd8;
    localparam logic [3:0]  LAST_SLOT   = 4'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WORD,
        ST_DATA,
        ST_TX,
        ST_SKIP,
        ST_FLUSH
    } eel_state_t;

    typedef struct packed {
        logic [3:0] fam;
        logic [2:0] sel;
        logic       rd;
    } ctl_byte_t;

    function automatic logic ctl_hit(input ctl_byte_t b, input logic [2:0] strap);
        return (b.fam == FAMILY_CODE) && (b.sel == strap);
    endfunction

    function automatic logic [3:0] slot_next(input logic [3:0] s);
        return (s == ACK_SLOT) ? 4'd0 : s + 4'd1;
    endfunction

endpackage

// File: rtl/eel_bitslot.sv
module eel_bitslot
    import eel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic              bit_in,
    output logic [3:0]        slot,
    output logic [BYTE_W-1:0] byte_now,
    output logic              last_bit,
    output logic              ack_bit
);

    logic [BYTE_W-2:0] sh;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            slot <= '0;
            sh   <= '0;
        end else if (take) begin
            slot <= slot_next(slot);
            if (slot != ACK_SLOT)
                sh <= {sh[BYTE_W-3:0], bit_in};
        end
    end

    assign byte_now = {sh, bit_in};
    assign last_bit = (slot == LAST_SLOT);
    assign ack_bit  = (slot == ACK_SLOT);

endmodule

// File: rtl/eel_pagebuf.sv
module eel_pagebuf
    import eel_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              put,
    input  logic [PAGE_W-1:0] put_idx,
    input  logic [BYTE_W-1:0] put_data,
    input  logic              go,
    input  logic [ADDR_W-PAGE_W-1:0] go_base,
    output logic              any_held,
    output logic              flushing,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    localparam int DEPTH = 1 << PAGE_W;
    localparam int HI_W  = ADDR_W - PAGE_W;

    logic [BYTE_W-1:0] store [DEPTH];
    logic [DEPTH-1:0]  held;
    logic [PAGE_W-1:0] idx;
    logic [HI_W-1:0]   base;

    always_ff @(posedge clk) begin
        if (put && !go && !flushing && !clear)
            store[put_idx] <= put_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= '0;
            flushing <= 1'b0;
            idx      <= '0;
            base     <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (go) begin
                flushing <= 1'b1;
                idx      <= '0;
                base     <= go_base;
            end else if (flushing) begin
                if (held[idx]) begin
                    wr_en   <= 1'b1;
                    wr_addr <= {base, idx};
                    wr_data <= store[idx];
                end
                held[idx] <= 1'b0;
                idx       <= idx + 1'b1;
                if (&idx)
                    flushing <= 1'b0;
            end else if (clear) begin
                held <= '0;
            end else if (put) begin
                held[put_idx] <= 1'b1;
            end
        end
    end

    assign any_held = |held;

endmodule

// File: rtl/eel_link_engine.sv
module eel_link_engine
    import eel_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              scl_fall,
    input  logic              bit_valid,
    input  logic              bit_val,
    input  logic [2:0]        dev_sel,
    input  logic              wr_lock,
    input  logic              cycle_busy,
    input  logic [7:0]        mem_rdata,
    output logic              sda_pull,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              wr_launch
);

    localparam int HI_W = ADDR_W - PAGE_W;

    eel_state_t        st, after;
    logic [ADDR_W-1:0] ptr, rd_addr, ptr_page_inc;
    logic              ack_ok, rd_q, rd_pend, pull_q, launch_q, drive;
    logic [BYTE_W-1:0] tx;

    logic              live, take, commit, put, pb_clear;
    logic [3:0]        slot;
    logic [BYTE_W-1:0] byte_now;
    logic              last_bit, ack_bit;
    ctl_byte_t         cb;

    logic              pb_any, pb_flushing, pb_wr;
    logic [ADDR_W-1:0] pb_addr;
    logic [BYTE_W-1:0] pb_data;

    assign live     = (st != ST_FLUSH) && !cycle_busy;
    assign take     = live && bit_valid && !bus_start && !bus_stop;
    assign commit   = live && bus_stop && !bus_start && (st == ST_DATA) &&
                      (slot == 4'd0) && pb_any && !wr_lock;
    assign pb_clear = live && (bus_start || bus_stop) && !commit;
    assign put      = take && (st == ST_DATA) && last_bit && !wr_lock;
    assign cb       = ctl_byte_t'(byte_now);
    assign ptr_page_inc = {ptr[ADDR_W-1:PAGE_W], PAGE_W'(ptr[PAGE_W-1:0] + 1'b1)};

    eel_bitslot u_slot (
        .clk      (clk),
        .rst      (rst),
        .clear    (live && (bus_start || bus_stop)),
        .take     (take),
        .bit_in   (bit_val),
        .slot     (slot),
        .byte_now (byte_now),
        .last_bit (last_bit),
        .ack_bit  (ack_bit)
    );

    eel_pagebuf #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_page (
        .clk      (clk),
        .rst      (rst),
        .clear    (pb_clear),
        .put      (put),
        .put_idx  (ptr[PAGE_W-1:0]),
        .put_data (byte_now),
        .go       (commit),
        .go_base  (ptr[ADDR_W-1:ADDR_W-HI_W]),
        .any_held (pb_any),
        .flushing (pb_flushing),
        .wr_en    (pb_wr),
        .wr_addr  (pb_addr),
        .wr_data  (pb_data)
    );

    // Level to present on SDA for the slot that the next SCL high belongs to.
    always_comb begin
        drive = 1'b0;
        case (st)
            ST_ADDR, ST_WORD, ST_DATA: drive = (slot == ACK_SLOT) && ack_ok;
            ST_TX:   if (slot != ACK_SLOT) drive = !tx[3'd7 - slot[2:0]];
            default: drive = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            after    <= ST_IDLE;
            ptr      <= '0;
            rd_addr  <= '0;
            ack_ok   <= 1'b0;
            rd_q     <= 1'b0;
            rd_pend  <= 1'b0;
            tx       <= '0;
            pull_q   <= 1'b0;
            launch_q <= 1'b0;
        end else begin
            rd_q     <= 1'b0;
            launch_q <= commit;
            rd_pend  <= rd_q;
            if (rd_pend)
                tx <= mem_rdata;

            if (st == ST_FLUSH) begin
                pull_q <= 1'b0;
                if (!pb_flushing)
                    st <= ST_IDLE;
            end else if (cycle_busy) begin
                pull_q <= 1'b0;
                ack_ok <= 1'b0;
                st     <= ST_IDLE;
            end else if (bus_start) begin
                pull_q <= 1'b0;
                ack_ok <= 1'b0;
                st     <= ST_ADDR;
            end else if (bus_stop) begin
                pull_q <= 1'b0;
                ack_ok <= 1'b0;
                st     <= commit ? ST_FLUSH : ST_IDLE;
            end else begin
                if (scl_fall)
                    pull_q <= drive;
                if (bit_valid) begin
                    case (st)
                        ST_ADDR: begin
                            if (last_bit) begin
                                if (ctl_hit(cb, dev_sel)) begin
                                    ack_ok <= 1'b1;
                                    if (cb.rd) begin
                                        rd_q    <= 1'b1;
                                        rd_addr <= ptr;
                                        ptr     <= ptr + 1'b1;
                                        after   <= ST_TX;
                                    end else begin
                                        after   <= ST_WORD;
                                    end
                                end else begin
                                    ack_ok <= 1'b0;
                                    st     <= ST_SKIP;
                                end
                            end else if (ack_bit) begin
                                ack_ok <= 1'b0;
                                st     <= after;
                            end
                        end
                        ST_WORD: begin
                            if (last_bit) begin
                                ptr    <= byte_now[ADDR_W-1:0];
                                ack_ok <= 1'b1;
                                after  <= ST_DATA;
                            end else if (ack_bit) begin
                                ack_ok <= 1'b0;
                                st     <= after;
                            end
                        end
                        ST_DATA: begin
                            if (last_bit) begin
                                if (wr_lock) begin
                                    ack_ok <= 1'b0;
                                    after  <= ST_SKIP;
                                end else begin
                                    ack_ok <= 1'b1;
                                    after  <= ST_DATA;
                                    ptr    <= ptr_page_inc;
                                end
                            end else if (ack_bit) begin
                                ack_ok <= 1'b0;
                                st     <= after;
                            end
                        end
                        ST_TX: begin
                            if (ack_bit) begin
                                if (!bit_val) begin
                                    rd_q    <= 1'b1;
                                    rd_addr <= ptr;
                                    ptr     <= ptr + 1'b1;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign sda_pull  = pull_q;
    assign mem_rd    = rd_q;
    assign mem_wr    = pb_wr;
    assign mem_addr  = pb_wr ? pb_addr : rd_addr;
    assign mem_wdata = pb_data;
    assign wr_launch = launch_q;

endmodule

// File: rtl/eel_link_checks.sv
module eel_link_checks (
    input logic clk,
    input logic rst,
    input logic bus_start,
    input logic bus_stop,
    input logic cycle_busy,
    input logic wr_lock,
    input logic sda_pull,
    input logic mem_rd,
    input logic mem_wr,
    input logic wr_launch
);

    p_quiet_busy_r7: assert property (@(posedge clk) disable iff (rst)
        cycle_busy |=> !sda_pull);

    p_busy_noread_r7: assert property (@(posedge clk) disable iff (rst)
        cycle_busy |=> !mem_rd);

    p_locked_nolaunch_r6: assert property (@(posedge clk) disable iff (rst)
        wr_lock |=> !wr_launch);

    p_start_release_r12: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> !sda_pull);

    p_stop_release_r4: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> !sda_pull);

    p_launch_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        wr_launch |=> !wr_launch);

    p_port_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

bind eel_link_engine eel_link_checks u_chk (.*);

// File: tb/sim_eel_link_engine.sv
`timescale 1ns/1ps
module sim_eel_link_engine;

    localparam logic [7:0] DEV_W = 8'hAA;  // 1010 101 0
    localparam logic [7:0] DEV_R = 8'hAB;  // 1010 101 1
    localparam int BUSY_CYC = 120;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_start = 0, bus_stop = 0, scl_fall = 0, bit_valid = 0, bit_val = 0;
    logic [2:0] dev_sel = 3'b101;
    logic wr_lock = 0;
    logic cycle_busy;
    logic [7:0] mem_rdata;
    logic sda_pull, mem_rd, mem_wr, wr_launch;
    logic [7:0] mem_addr, mem_wdata;

    always #2 clk = ~clk;

    eel_link_engine u0 (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .scl_fall(scl_fall), .bit_valid(bit_valid), .bit_val(bit_val),
        .dev_sel(dev_sel), .wr_lock(wr_lock), .cycle_busy(cycle_busy),
        .mem_rdata(mem_rdata), .sda_pull(sda_pull), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wr_launch(wr_launch)
    );

    // Memory array and write-cycle controller models.
    logic [7:0] mem_arr [256];
    int busy_cnt;
    int launches;
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem_arr[i] <= 8'(i * 7 + 3);
            mem_rdata <= '0;
            busy_cnt  <= 0;
            launches  <= 0;
        end else begin
            if (mem_wr) mem_arr[mem_addr] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem_arr[mem_addr];
            if (wr_launch) begin
                busy_cnt <= BUSY_CYC;
                launches <= launches + 1;
            end else if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end
    assign cycle_busy = (busy_cnt != 0);

    // Reference state.
    logic [7:0] ref_mem [256];
    int ref_ptr;
    int checks = 0;
    int fails  = 0;
    logic exp_pull = 1'b0;
    logic chk_on = 1'b0;
    string cur_req = "R13";

    always @(negedge clk) begin
        if (chk_on) begin
            checks++;
            if (sda_pull !== exp_pull) begin
                fails++;
                $display("FAIL %s: sda_pull=%b expected %b at %0t", cur_req, sda_pull, exp_pull, $time);
            end
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_slot(input logic mbit, input logic xp, output logic busv);
        @(negedge clk); scl_fall = 1'b1;
        @(posedge clk); #1 exp_pull = xp;
        @(negedge clk); scl_fall = 1'b0;
        @(negedge clk); busv = mbit & ~sda_pull; bit_val = busv; bit_valid = 1'b1;
        @(negedge clk); bit_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic start_c();
        @(negedge clk); bus_start = 1'b1;
        @(posedge clk); #1 exp_pull = 1'b0;
        @(negedge clk); bus_start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic stop_c();
        @(negedge clk); bus_stop = 1'b1;
        @(posedge clk); #1 exp_pull = 1'b0;
        @(negedge clk); bus_stop = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        logic bv;
        cur_req = req;
        for (int i = 7; i >= 0; i--) do_slot(b[i], 1'b0, bv);
        do_slot(1'b1, exp_ack, bv);
        check_eq(req, "ack level", int'(bv), int'(!exp_ack));
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string req);
        logic bv;
        logic [7:0] got;
        cur_req = req;
        for (int i = 7; i >= 0; i--) begin
            do_slot(1'b1, !exp[i], bv);
            got[i] = bv;
        end
        do_slot(!mack, 1'b0, bv);
        check_eq(req, "read data", int'(got), int'(exp));
    endtask

    task automatic partial(input int n, input string req);
        logic bv;
        cur_req = req;
        for (int i = 0; i < n; i++) do_slot(1'b1, 1'b0, bv);
    endtask

    task automatic wait_ready();
        while (cycle_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_txn(input logic [7:0] a, input int n, input logic [7:0] seed,
                          input logic locked, input string req);
        int l0;
        logic [3:0] lo;
        l0 = launches;
        start_c();
        send_byte(DEV_W, 1'b1, "R1");
        send_byte(a, 1'b1, "R3");
        for (int k = 0; k < n; k++) begin
            send_byte(8'(seed + k * 13), !locked, locked ? "R6" : req);
            if (!locked) begin
                lo = 4'(a[3:0] + k);
                ref_mem[{a[7:4], lo}] = 8'(seed + k * 13);
            end
        end
        if (locked) ref_ptr = a;
        else ref_ptr = {a[7:4], 4'(a[3:0] + n)};
        stop_c();
        repeat (4) @(negedge clk);
        check_eq(locked ? "R6" : "R4", "launch count", launches, l0 + (locked ? 0 : 1));
        if (!locked) begin
            // R7: poll while the write cycle runs, then after it ends
            start_c();
            send_byte(DEV_W, 1'b0, "R7");
            stop_c();
            check_eq("R7", "busy during poll", int'(cycle_busy), 1);
            wait_ready();
            start_c();
            send_byte(DEV_W, 1'b1, "R7");
            stop_c();
        end
    endtask

    task automatic rd_rand(input logic [7:0] a, input int n, input string req);
        start_c();
        send_byte(DEV_W, 1'b1, "R1");
        send_byte(a, 1'b1, "R10");
        start_c();
        send_byte(DEV_R, 1'b1, "R1");
        ref_ptr = a;
        for (int k = 0; k < n; k++) begin
            recv_byte(ref_mem[ref_ptr], k < n - 1, req);
            ref_ptr = (ref_ptr + 1) % 256;
        end
        stop_c();
    endtask

    task automatic rd_cur(input int n, input string req);
        start_c();
        send_byte(DEV_R, 1'b1, "R1");
        for (int k = 0; k < n; k++) begin
            recv_byte(ref_mem[ref_ptr], k < n - 1, req);
            ref_ptr = (ref_ptr + 1) % 256;
        end
        stop_c();
    endtask

    initial begin
        int l0;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 7 + 3);
        ref_ptr = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13: reset state
        check_eq("R13", "sda_pull", int'(sda_pull), 0);
        check_eq("R13", "mem_wr", int'(mem_wr), 0);
        check_eq("R13", "mem_rd", int'(mem_rd), 0);
        check_eq("R13", "wr_launch", int'(wr_launch), 0);
        chk_on = 1'b1;

        // R3 R4 R7: byte write, then current read at n+1 (R9)
        wr_txn(8'h20, 1, 8'h5A, 1'b0, "R3");
        rd_cur(1, "R9");
        // R10: random read of the written byte, then R9 again
        rd_rand(8'h20, 1, "R10");
        rd_cur(2, "R9");

        // R5: page wrap inside one page, then sequential read (R8 R11)
        wr_txn(8'h3C, 6, 8'h71, 1'b0, "R5");
        rd_rand(8'h30, 16, "R5");
        // R5: 18 bytes overwrite the first two of the page
        wr_txn(8'h40, 18, 8'h05, 1'b0, "R5");
        rd_rand(8'h40, 16, "R5");

        // R11: sequential wrap 255 -> 0
        rd_rand(8'hFE, 4, "R11");

        // R11: after NACK the engine stays silent until the next start
        start_c();
        send_byte(DEV_R, 1'b1, "R1");
        recv_byte(ref_mem[ref_ptr], 1'b0, "R8");
        ref_ptr = (ref_ptr + 1) % 256;
        partial(9, "R11");
        stop_c();

        // R2: wrong select and wrong family code
        start_c();
        send_byte(8'hA4, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        stop_c();
        start_c();
        send_byte(8'hBB, 1'b0, "R2");
        partial(9, "R2");
        stop_c();
        rd_cur(1, "R2");

        // R6: locked array
        wr_lock = 1'b1;
        wr_txn(8'h90, 1, 8'hC3, 1'b1, "R6");
        repeat (3) @(negedge clk);
        wr_lock = 1'b0;
        rd_rand(8'h90, 1, "R6");

        // R12: stop in mid byte discards pending data
        l0 = launches;
        start_c();
        send_byte(DEV_W, 1'b1, "R1");
        send_byte(8'h80, 1'b1, "R3");
        send_byte(8'h11, 1'b1, "R3");
        partial(4, "R12");
        stop_c();
        repeat (4) @(negedge clk);
        check_eq("R12", "launch after mid-byte stop", launches, l0);
        ref_ptr = 8'h81;
        rd_cur(1, "R12");
        rd_rand(8'h80, 1, "R12");

        // R12: start in mid byte restarts control byte reception
        l0 = launches;
        start_c();
        send_byte(DEV_W, 1'b1, "R1");
        send_byte(8'hC0, 1'b1, "R3");
        send_byte(8'h22, 1'b1, "R3");
        partial(3, "R12");
        start_c();
        send_byte(DEV_R, 1'b1, "R12");
        recv_byte(ref_mem[8'hC1], 1'b0, "R12");
        stop_c();
        repeat (4) @(negedge clk);
        check_eq("R12", "launch after mid-byte start", launches, l0);
        rd_rand(8'hC0, 1, "R12");

        repeat (5) @(negedge clk);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule